// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one burst request into the string of column addresses that an SDRAM controller puts on the bus, one address per clock. A single-cycle start pulse captures a 9-bit starting column, a read/write flag and the mode fields: a length code, an ordering bit, a write-single bit and a two-bit operating-mode field. From the next cycle on, the block emits one column per clock with a valid flag and marks the final beat with a last flag.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the starting column. The low column bits step through that block, either by adding the beat number (sequential order) or by XOR-ing it in (interleaved order), and they wrap back to the start of the block when they reach its end. A full-page burst walks sequentially through all 512 columns of the row, wrapping from 511 to 0, until a terminate input ends it. Writes can be forced to single-location accesses. Reserved mode settings raise an error flag and produce no addresses.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, valid_o, last_o and err_o are low.
- R2: A legal start pulse sampled at a rising edge makes the first column appear with valid_o high from that edge; each later beat appears one clock after the previous one, with valid_o high on every beat.
- R3: Length code 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8; last_o is high on the final beat only, and valid_o is low in the cycle after it unless a new burst starts.
- R4: In a fixed burst of N beats, column bits above the low log2(N) bits equal those of the starting column on every beat.
- R5: With the ordering bit at 0, beat k has low bits (s + k) mod N, where s is the starting column's low bits; for example length 4 from 2 gives 2, 3, 0, 1.
- R6: With the ordering bit at 1, beat k has low bits s XOR k; for example length 8 from 5 gives 5, 4, 7, 6, 1, 0, 3, 2. At length 1 the ordering bit has no effect.
- R7: Length code 3'b111 is a full-page burst: column is (start + k) mod 512, and it runs until term_i is high during a beat, which then carries last_o; valid_o is low in the next cycle. term_i has no effect on fixed-length bursts.
- R8: When wr_single_i is 1, a write burst is one beat at the starting column with last_o high, whatever the length code; reads keep the programmed length. When wr_single_i is 0, writes use the programmed length.
- R9: A start is rejected when op_mode_i is not 2'b00, when the length code is 3'b100, 3'b101 or 3'b110, or when the effective burst is full page with the ordering bit at 1 (a full-page write forced to one beat is legal). A rejected start gives err_o high for exactly the next cycle, valid_o low, and ends any burst in progress.
- R10: A legal start pulse during an active burst abandons it; the next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle burst request |
| start_col_i | input | 9 | Starting column |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read |
| len_code_i | input | 3 | Burst length code |
| order_il_i | input | 1 | 0 sequential, 1 interleaved ordering |
| wr_single_i | input | 1 | 1 forces single-location writes |
| op_mode_i | input | 2 | Operating mode, 2'b00 is the only normal value |
| term_i | input | 1 | Ends a full-page burst on the current beat |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous cycle's start was rejected |

## Verification
The assertions watch, on every cycle, the framing of the output stream: a last beat is always a valid beat, an error cycle never carries a beat and always follows a start, every start yields either a first beat or an error, a last beat without a new start is followed by an idle cycle, and a fixed burst never leaves its aligned 8-column group. The exact orderings, the wrap points, the beat counts per length code, the write-single override, the terminate behaviour of full-page bursts and the abandon-on-restart timing depend on specific column values and can only be shown by the bench's scenarios, which compare every beat against values computed from the requirements.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } len_code_e;

  localparam logic [1:0] OPM_NORMAL = 2'b00;

endpackage

// File: rtl/bcs_mode_dec.sv
module bcs_mode_dec
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       len_code,
  input  logic             order_il,
  input  logic             is_write,
  input  logic             wr_single,
  input  logic [1:0]       op_mode,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             il_eff,
  output logic             bad
);

  logic [COL_W-1:0] prog_mask;
  logic             prog_full;
  logic             reserved_len;
  logic             force_one;

  // programmed length -> low-bit mask
  always_comb begin
    prog_mask    = '0;
    prog_full    = 1'b0;
    reserved_len = 1'b0;
    unique case (len_code)
      LEN_ONE:   prog_mask = '0;
      LEN_TWO:   prog_mask = COL_W'(1);
      LEN_FOUR:  prog_mask = COL_W'(3);
      LEN_EIGHT: prog_mask = COL_W'(7);
      LEN_PAGE: begin
        prog_mask = '1;
        prog_full = 1'b1;
      end
      default:   reserved_len = 1'b1;
    endcase
  end

  assign force_one = is_write & wr_single;

  // effective length after the write-single override
  always_comb begin
    if (force_one) begin
      mask = '0;
      full = 1'b0;
    end else begin
      mask = prog_mask;
      full = prog_full;
    end
  end

  assign il_eff = order_il & (mask != '0);
  assign bad    = reserved_len | (op_mode != OPM_NORMAL) | (full & order_il);

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             il,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] il_low;
  logic [COL_W-1:0] low_sel;

  assign seq_low = base + beat;
  assign il_low  = base ^ beat;
  assign low_sel = il ? il_low : seq_low;
  assign col     = (base & ~mask) | (low_sel & mask);

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bad,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             il_in,
  input  logic             term,
  output logic             active_q,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output logic             il_q,
  output logic             full_q,
  output logic             last,
  output logic             err_q
);

  logic             active_n;
  logic             err_n;
  logic [COL_W-1:0] beat_n;
  logic             cfg_en;
  logic             beat_en;

  assign last = active_q & (full_q ? term : (beat_q == mask_q));

  // next state
  always_comb begin
    active_n = active_q;
    beat_n   = beat_q;
    cfg_en   = 1'b0;
    beat_en  = 1'b0;
    err_n    = 1'b0;
    if (start) begin
      beat_en = 1'b1;
      beat_n  = '0;
      if (bad) begin
        active_n = 1'b0;
        err_n    = 1'b1;
      end else begin
        active_n = 1'b1;
        cfg_en   = 1'b1;
      end
    end else if (active_q) begin
      if (last) begin
        active_n = 1'b0;
      end else begin
        beat_en = 1'b1;
        beat_n  = beat_q + COL_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      err_q    <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      il_q   <= 1'b0;
      full_q <= 1'b0;
    end else if (cfg_en) begin
      base_q <= start_col;
      mask_q <= mask_in;
      il_q   <= il_in;
      full_q <= full_in;
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             is_write_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_il_i,
  input  logic             wr_single_i,
  input  logic [1:0]       op_mode_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_il;
  logic             dec_bad;

  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             il_q;
  logic             full_q;
  logic             last_w;
  logic             err_q;

  bcs_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code  (len_code_i),
    .order_il  (order_il_i),
    .is_write  (is_write_i),
    .wr_single (wr_single_i),
    .op_mode   (op_mode_i),
    .mask      (dec_mask),
    .full      (dec_full),
    .il_eff    (dec_il),
    .bad       (dec_bad)
  );

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start_i),
    .bad       (dec_bad),
    .start_col (start_col_i),
    .mask_in   (dec_mask),
    .full_in   (dec_full),
    .il_in     (dec_il),
    .term      (term_i),
    .active_q  (active_q),
    .base_q    (base_q),
    .beat_q    (beat_q),
    .mask_q    (mask_q),
    .il_q      (il_q),
    .full_q    (full_q),
    .last      (last_w),
    .err_q     (err_q)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_gen (
    .base (base_q),
    .beat (beat_q),
    .mask (mask_q),
    .il   (il_q),
    .col  (col_o)
  );

  assign valid_o = active_q;
  assign last_o  = last_w;
  assign err_o   = err_q;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o,
  input logic             full_q
);

  localparam int BLK_LG = 3;

  // R3: a final beat is always a beat
  a_r3_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R3: after a final beat with no new request, the output goes idle
  a_r3_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  // R9: an error cycle carries no beat
  a_r9_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

  // R9: an error only follows a request
  a_r9_err_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i));

  // R2: every request yields a first beat or an error
  a_r2_start_answered: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o || err_o));

  // R4: fixed bursts keep their aligned group of columns
  a_r4_stay_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && !$past(last_o) && !$past(start_i) && !full_q)
      |-> (col_o[COL_W-1:BLK_LG] == $past(col_o[COL_W-1:BLK_LG])));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o),
  .err_o   (err_o),
  .full_q  (full_q)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [8:0] start_col_i;
  logic       is_write_i;
  logic [2:0] len_code_i;
  logic       order_il_i;
  logic       wr_single_i;
  logic [1:0] op_mode_i;
  logic       term_i;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       err_o;

  int checks;
  int errors;

  burst_col_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .is_write_i(is_write_i), .len_code_i(len_code_i), .order_il_i(order_il_i),
    .wr_single_i(wr_single_i), .op_mode_i(op_mode_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {len_code, order_il, is_write, wr_single, start_col}
  localparam int NV = 11;
  localparam logic [14:0] VECS [NV] = '{
    {3'd1, 1'b0, 1'b0, 1'b0, 9'h0A3},
    {3'd2, 1'b0, 1'b0, 1'b0, 9'h002},
    {3'd2, 1'b1, 1'b0, 1'b0, 9'h1F1},
    {3'd3, 1'b0, 1'b0, 1'b0, 9'h0D5},
    {3'd3, 1'b1, 1'b0, 1'b0, 9'h005},
    {3'd0, 1'b1, 1'b0, 1'b0, 9'h1AB},
    {3'd3, 1'b1, 1'b1, 1'b1, 9'h033},
    {3'd3, 1'b0, 1'b1, 1'b0, 9'h1FE},
    {3'd2, 1'b0, 1'b0, 1'b1, 9'h10F},
    {3'd1, 1'b1, 1'b1, 1'b0, 9'h100},
    {3'd7, 1'b1, 1'b1, 1'b1, 9'h155}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 512;
    endcase
  endfunction

  function automatic int exp_col(input int n, input bit il, input int col, input int k);
    int off;
    int blk;
    off = col % n;
    blk = col - off;
    if (il) return blk + (off ^ k);
    return blk + ((off + k) % n);
  endfunction

  task automatic idle_inputs();
    start_i = 1'b0; start_col_i = '0; is_write_i = 1'b0; len_code_i = 3'd0;
    order_il_i = 1'b0; wr_single_i = 1'b0; op_mode_i = 2'b00; term_i = 1'b0;
  endtask

  task automatic pulse_start(input logic [2:0] lc, input bit il, input bit wr,
                             input bit ws, input logic [8:0] col);
    start_i = 1'b1; len_code_i = lc; order_il_i = il; is_write_i = wr;
    wr_single_i = ws; start_col_i = col;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // checks a whole fixed burst starting at the current negedge
  task automatic walk(input int n, input bit il, input int col, input string req);
    for (int k = 0; k < n; k++) begin
      chk(valid_o === 1'b1, req, valid_o, 1);
      chk(col_o == 9'(exp_col(n, il, col, k)), req, col_o, exp_col(n, il, col, k));
      chk(last_o === (k == n - 1), req, last_o, (k == n - 1));
      @(negedge clk);
    end
    chk(valid_o === 1'b0, req, valid_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(valid_o === 1'b0 && last_o === 1'b0 && err_o === 1'b0, "R1", {valid_o, last_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o === 1'b0 && last_o === 1'b0 && err_o === 1'b0, "R1", {valid_o, last_o, err_o}, 0);
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5 R6 R8: table of bursts
    for (int v = 0; v < NV; v++) begin
      logic [2:0] lc;
      bit il, wr, ws;
      logic [8:0] col;
      int n;
      {lc, il, wr, ws, col} = VECS[v];
      n = (wr && ws) ? 1 : len_of(lc);
      pulse_start(lc, il, wr, ws, col);
      walk(n, il && (n > 1), int'(col), "R2/R3/R4/R5/R6/R8 table");
    end

    // R7: full page wraps 511 -> 0 and ends on term
    pulse_start(3'd7, 1'b0, 1'b0, 1'b0, 9'h1FE);
    for (int k = 0; k < 6; k++) begin
      if (k == 5) begin
        term_i = 1'b1;
        #1;
      end
      chk(valid_o === 1'b1, "R7 full page valid", valid_o, 1);
      chk(col_o == 9'((510 + k) % 512), "R7 full page column", col_o, (510 + k) % 512);
      chk(last_o === (k == 5), "R7 last on term", last_o, (k == 5));
      @(negedge clk);
    end
    term_i = 1'b0;
    chk(valid_o === 1'b0, "R7 idle after term", valid_o, 0);

    // R7: term has no effect on a fixed burst
    term_i = 1'b1;
    pulse_start(3'd2, 1'b0, 1'b0, 1'b0, 9'h000);
    walk(4, 1'b0, 0, "R7 term ignored");
    term_i = 1'b0;

    // R10: restart mid-burst
    pulse_start(3'd3, 1'b0, 1'b0, 1'b0, 9'h040);
    for (int k = 0; k < 3; k++) begin
      chk(col_o == 9'(9'h040 + k), "R10 first burst", col_o, 9'h040 + k);
      if (k < 2) @(negedge clk);
    end
    pulse_start(3'd2, 1'b1, 1'b0, 1'b0, 9'h022);
    walk(4, 1'b1, 9'h022, "R10 restart");

    // R9: non-normal operating mode
    op_mode_i = 2'b01;
    pulse_start(3'd2, 1'b0, 1'b0, 1'b0, 9'h010);
    chk(err_o === 1'b1, "R9 op mode err", err_o, 1);
    chk(valid_o === 1'b0, "R9 op mode no beat", valid_o, 0);
    @(negedge clk);
    chk(err_o === 1'b0 && valid_o === 1'b0, "R9 err one cycle", {err_o, valid_o}, 0);
    op_mode_i = 2'b00;

    // R9: reserved length code
    pulse_start(3'd4, 1'b0, 1'b0, 1'b0, 9'h010);
    chk(err_o === 1'b1 && valid_o === 1'b0, "R9 reserved length", {err_o, valid_o}, 2);
    @(negedge clk);

    // R9: interleaved full page read, issued over an active burst
    pulse_start(3'd3, 1'b0, 1'b0, 1'b0, 9'h080);
    chk(valid_o === 1'b1, "R9 burst running", valid_o, 1);
    pulse_start(3'd7, 1'b1, 1'b0, 1'b0, 9'h000);
    chk(err_o === 1'b1 && valid_o === 1'b0, "R9 interleaved page abandons", {err_o, valid_o}, 2);
    @(negedge clk);
    chk(valid_o === 1'b0 && err_o === 1'b0, "R9 stays idle", {err_o, valid_o}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule